// File: doc/BRIEF.md
# Accelerating Orbit-Camera Button Controller

This block turns a bank of raw push-buttons into the three viewing parameters that a wireframe projection pipeline consumes: an azimuth code, an elevation code and a viewing-angle (field-of-view) code. It also produces a model index and a one-cycle global reset request. Every button first passes through a flop synchroniser. All motion is paced by a tick enable, so the front end sets how fast the camera turns without any change to the clock.

Azimuth and elevation speed up while a button stays down. The step starts at one code per tick and doubles after every 32 ticks of unbroken hold, up to eight codes per tick. It drops back to one as soon as the button is released or the direction reverses. Azimuth wraps around a full turn of 256 codes. Elevation and viewing angle saturate at configurable limits and never wrap, and the viewing angle always moves one code per tick.

Pressing both buttons of one axis at once is a chord command, and the axis does not move while it is held. The azimuth pair steps the model index once per press. The elevation pair must stay down for 16 ticks before it issues a reset pulse.

Top module: `orbit_input_ctrl`

## Requirements
- R1: Each raw button passes through a two-flop synchroniser. A press that first appears before clock edge 1 has no effect on ticks at edges 1 and 2, and takes effect on a tick at edge 3.
- R2: Azimuth, elevation, viewing angle and the reset-hold count change only on clock edges where `tick` is high.
- R3: Button bit 0 raises azimuth and bit 1 lowers it, modulo 256, so that 255 plus 1 gives 0 and 0 minus 1 gives 255.
- R4: While a single direction of azimuth or elevation is held, the step on the k-th tick of the hold (k counted from 0) is 1 for k below 32, 2 for k from 32 to 63, 4 for k from 64 to 95, and 8 from then on.
- R5: A release or a direct reversal of direction restarts the hold, so the next tick moves by 1.
- R6: Button bit 2 raises elevation and bit 3 lowers it. Elevation saturates at 16 and 112 and does not wrap.
- R7: Button bit 4 raises the viewing angle and bit 5 lowers it. It moves by 1 per tick with no acceleration and saturates at 8 and 200.
- R8: While both buttons of one axis are pressed, that axis does not move.
- R9: A rising edge of the chord of bits 0 and 1 advances `model_sel` by one, at most once per press, and the index wraps after 3 models (0, 1, 2, 0).
- R10: Holding the chord of bits 2 and 3 for 16 ticks raises `reset_req` for exactly one cycle. The pulse is issued once per hold, and a release before the 16th tick restarts the count.
- R11: After `rst`, azimuth is 0, elevation 64, viewing angle 60, `model_sel` 0 and `reset_req` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Rate enable for all counting |
| btn_raw | input | 6 | Asynchronous buttons: 0 az up, 1 az down, 2 el up, 3 el down, 4 view up, 5 view down |
| azimuth | output | 8 | Azimuth code, wraps |
| elevation | output | 8 | Elevation code, saturating |
| view_angle | output | 8 | Viewing-angle code, saturating |
| model_sel | output | 2 | Selected model index |
| reset_req | output | 1 | One-cycle global reset request |

## Verification
The bench holds single buttons for tick counts chosen to end inside each speed band and past the last doubling. Results that cross 256 show whether azimuth wraps, and runs that overshoot show whether elevation and viewing angle clamp at the right limit. Direct reversals and release-and-repress sequences show whether the hold restarts, which a counter that only clears on release would miss. Chord runs show the three command cases apart: a reset hold one tick short of 16 gives no pulse, an exact 16 gives one pulse, and a long hold still gives only one. They also check that model stepping happens once per press and wraps at three models, and that the axes stay still while a chord is held.

// File: rtl/orbit_pkg.sv
package orbit_pkg;
  localparam int BTN_N     = 6;
  localparam int B_AZ_UP   = 0;
  localparam int B_AZ_DN   = 1;
  localparam int B_EL_UP   = 2;
  localparam int B_EL_DN   = 3;
  localparam int B_VW_UP   = 4;
  localparam int B_VW_DN   = 5;

  typedef struct packed {
    logic up;
    logic dn;
  } axis_req_t;
endpackage

// File: rtl/orbit_sync.sv
module orbit_sync #(
  parameter int N      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);
  logic [STAGES-1:0][N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/orbit_accel.sv
module orbit_accel #(
  parameter int DOUBLE_TICKS = 32,
  parameter int MAX_LOG      = 3,
  localparam int SW          = MAX_LOG + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          up,
  input  logic          dn,
  output logic [SW-1:0] step
);
  localparam int CMAX = DOUBLE_TICKS * MAX_LOG;
  localparam int CW   = $clog2(CMAX + 1);

  logic [1:0]    req, req_q;
  logic          restart;
  logic [CW-1:0] cnt, base;
  int            lvl;

  assign req     = {up, dn};
  assign restart = (req == 2'b00) || (req != req_q);
  assign base    = restart ? '0 : cnt;

  always_comb begin
    lvl = int'(base) / DOUBLE_TICKS;
    if (lvl > MAX_LOG) lvl = MAX_LOG;
    step = SW'(1) << lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      cnt   <= '0;
    end else begin
      req_q <= req;
      if (tick && req != 2'b00)
        cnt <= (base == CW'(CMAX)) ? base : base + 1'b1;
      else
        cnt <= base;
    end
  end

  // R4: the step is always a single power of two no larger than the cap
  p_step_pow2_r4: assert property (@(posedge clk) disable iff (rst)
    ($countones(step) == 1) && (step <= SW'(1 << MAX_LOG)));
  // R5: an idle cycle restarts the step at one
  p_step_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (req == 2'b00) |=> (step == SW'(1)));
endmodule

// File: rtl/orbit_axis.sv
module orbit_axis #(
  parameter int W            = 8,
  parameter bit WRAP         = 1'b1,
  parameter bit ACCEL        = 1'b1,
  parameter int LO           = 0,
  parameter int HI           = 255,
  parameter int INIT         = 0,
  parameter int DOUBLE_TICKS = 32,
  parameter int MAX_LOG      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] val
);
  logic         mv_up, mv_dn;
  logic [W:0]   step_x, sum, dif, nxt_w;
  logic [W-1:0] nxt;

  assign mv_up = up & ~dn;
  assign mv_dn = dn & ~up;

  generate
    if (ACCEL) begin : g_accel
      logic [MAX_LOG:0] step_a;
      orbit_accel #(.DOUBLE_TICKS(DOUBLE_TICKS), .MAX_LOG(MAX_LOG)) u_accel (
        .clk(clk), .rst(rst), .tick(tick), .up(mv_up), .dn(mv_dn), .step(step_a)
      );
      assign step_x = (W+1)'(step_a);
    end else begin : g_unit
      assign step_x = (W+1)'(1);
    end
  endgenerate

  assign sum = {1'b0, val} + step_x;
  assign dif = {1'b0, val} - step_x;

  always_comb begin
    nxt_w = {1'b0, val};
    if (mv_up) begin
      if (WRAP) nxt_w = sum;
      else      nxt_w = (sum > (W+1)'(HI)) ? (W+1)'(HI) : sum;
    end else if (mv_dn) begin
      if (WRAP) nxt_w = dif;
      else      nxt_w = ({1'b0, val} < (W+1)'(LO) + step_x) ? (W+1)'(LO) : dif;
    end
    nxt = nxt_w[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       val <= W'(INIT);
    else if (tick) val <= nxt;
  end

  // R2: no tick, no motion
  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(val));
  // R8: opposed buttons freeze the axis
  p_opposed_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> $stable(val));

  generate
    if (!WRAP) begin : g_sat_chk
      // R6 / R7: a saturating axis stays inside its limits
      p_sat_range_r6: assert property (@(posedge clk) disable iff (rst)
        (val >= W'(LO)) && (val <= W'(HI)));
    end
  endgenerate
endmodule

// File: rtl/orbit_chords.sv
module orbit_chords #(
  parameter int MODEL_COUNT = 3,
  parameter int HOLD_TICKS  = 16,
  localparam int MW         = $clog2(MODEL_COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          model_chord,
  input  logic          reset_chord,
  output logic [MW-1:0] model_sel,
  output logic          reset_req
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic          chord_q;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chord_q   <= 1'b0;
      model_sel <= '0;
      hold_cnt  <= '0;
      reset_req <= 1'b0;
    end else begin
      chord_q <= model_chord;
      if (model_chord && !chord_q)
        model_sel <= (model_sel == MW'(MODEL_COUNT - 1)) ? '0 : model_sel + 1'b1;
      if (!reset_chord)
        hold_cnt <= '0;
      else if (tick && hold_cnt < HW'(HOLD_TICKS))
        hold_cnt <= hold_cnt + 1'b1;
      reset_req <= tick && reset_chord && (hold_cnt == HW'(HOLD_TICKS - 1));
    end
  end

  // R10: the reset request never lasts more than a cycle
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  // R10: a request only follows a held chord
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(reset_chord));
  // R9: index stays below the model count and holds during a held chord
  p_model_range_r9: assert property (@(posedge clk) disable iff (rst)
    model_sel <= MW'(MODEL_COUNT - 1));
  p_model_once_r9: assert property (@(posedge clk) disable iff (rst)
    (model_chord && chord_q) |=> $stable(model_sel));
endmodule

// File: rtl/orbit_input_ctrl.sv
module orbit_input_ctrl
  import orbit_pkg::*;
#(
  parameter int ANG_W        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int DOUBLE_TICKS = 32,
  parameter int STEP_LOG_MAX = 3,
  parameter int AZ_INIT      = 0,
  parameter int EL_MIN       = 16,
  parameter int EL_MAX       = 112,
  parameter int EL_INIT      = 64,
  parameter int VW_MIN       = 8,
  parameter int VW_MAX       = 200,
  parameter int VW_INIT      = 60,
  parameter int MODEL_COUNT  = 3,
  parameter int RESET_HOLD   = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  logic [BTN_N-1:0]               btn_raw,
  output logic [ANG_W-1:0]               azimuth,
  output logic [ANG_W-1:0]               elevation,
  output logic [ANG_W-1:0]               view_angle,
  output logic [$clog2(MODEL_COUNT)-1:0] model_sel,
  output logic                           reset_req
);
  logic [BTN_N-1:0] btn;
  axis_req_t        az_req, el_req, vw_req;

  orbit_sync #(.N(BTN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(btn_raw), .d_sync(btn)
  );

  assign az_req = '{up: btn[B_AZ_UP], dn: btn[B_AZ_DN]};
  assign el_req = '{up: btn[B_EL_UP], dn: btn[B_EL_DN]};
  assign vw_req = '{up: btn[B_VW_UP], dn: btn[B_VW_DN]};

  orbit_axis #(.W(ANG_W), .WRAP(1'b1), .ACCEL(1'b1), .LO(0), .HI((1 << ANG_W) - 1),
    .INIT(AZ_INIT), .DOUBLE_TICKS(DOUBLE_TICKS), .MAX_LOG(STEP_LOG_MAX)) u_az (
    .clk(clk), .rst(rst), .tick(tick), .up(az_req.up), .dn(az_req.dn), .val(azimuth)
  );

  orbit_axis #(.W(ANG_W), .WRAP(1'b0), .ACCEL(1'b1), .LO(EL_MIN), .HI(EL_MAX),
    .INIT(EL_INIT), .DOUBLE_TICKS(DOUBLE_TICKS), .MAX_LOG(STEP_LOG_MAX)) u_el (
    .clk(clk), .rst(rst), .tick(tick), .up(el_req.up), .dn(el_req.dn), .val(elevation)
  );

  orbit_axis #(.W(ANG_W), .WRAP(1'b0), .ACCEL(1'b0), .LO(VW_MIN), .HI(VW_MAX),
    .INIT(VW_INIT), .DOUBLE_TICKS(DOUBLE_TICKS), .MAX_LOG(STEP_LOG_MAX)) u_vw (
    .clk(clk), .rst(rst), .tick(tick), .up(vw_req.up), .dn(vw_req.dn), .val(view_angle)
  );

  orbit_chords #(.MODEL_COUNT(MODEL_COUNT), .HOLD_TICKS(RESET_HOLD)) u_chords (
    .clk(clk), .rst(rst), .tick(tick),
    .model_chord(az_req.up && az_req.dn),
    .reset_chord(el_req.up && el_req.dn),
    .model_sel(model_sel), .reset_req(reset_req)
  );

  // R11: outputs leave reset at their initial codes
  p_reset_state_r11: assert property (@(posedge clk)
    $past(rst) |-> (azimuth == ANG_W'(AZ_INIT)) && (elevation == ANG_W'(EL_INIT))
                   && (view_angle == ANG_W'(VW_INIT)) && !reset_req);
endmodule

// File: tb/test_orbit_input_ctrl.sv
module test_orbit_input_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] btn = '0;
  logic [7:0] az, el, vw;
  logic [1:0] msel;
  logic       rreq;

  int checks = 0, fails = 0;
  int pulses = 0, wide = 0;
  logic prev_req = 1'b0;
  int e_az = 0, e_el = 64, e_vw = 60, e_m = 0;

  always #2.5 clk = ~clk;

  orbit_input_ctrl i_orbit_input_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .btn_raw(btn),
    .azimuth(az), .elevation(el), .view_angle(vw), .model_sel(msel), .reset_req(rreq)
  );

  always @(negedge clk) begin
    if (rreq) pulses++;
    if (rreq && prev_req) wide++;
    prev_req = rreq;
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int step_at(int k);
    return (k / 32 >= 3) ? 8 : (1 << (k / 32));
  endfunction

  function automatic int run_axis(int v, bit up, int n, bit wrap, bit accel, int lo, int hi);
    for (int k = 0; k < n; k++) begin
      int s = accel ? step_at(k) : 1;
      v = up ? v + s : v - s;
      if (wrap) v = ((v % 256) + 256) % 256;
      else if (v > hi) v = hi;
      else if (v < lo) v = lo;
    end
    return v;
  endfunction

  task automatic press(logic [5:0] b);
    btn = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    check({req, " azimuth"}, az, e_az);
    check({req, " elevation"}, el, e_el);
    check({req, " view"}, vw, e_vw);
    check({req, " model"}, msel, e_m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R11 reset");
    check("R11 reset_req", rreq, 0);

    // R1: synchroniser latency
    btn = 6'b000001; tick = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no effect before sync", az, e_az);
    @(negedge clk);
    tick = 1'b0;
    e_az = 1;
    check("R1 effect after sync", az, e_az);
    press(6'b0);

    // R2: no tick, no motion
    press(6'b010101);
    repeat (20) @(negedge clk);
    check_all("R2 tick gating");
    press(6'b0);

    // R3/R4: azimuth bands and wrap
    press(6'b000001); ticks(10);
    e_az = run_axis(e_az, 1, 10, 1, 1, 0, 255);
    check("R4 band one", az, e_az);
    press(6'b0); press(6'b000001); ticks(110);
    e_az = run_axis(e_az, 1, 110, 1, 1, 0, 255);
    check("R3 R4 all bands, wrap up", az, e_az);
    press(6'b0); press(6'b000010); ticks(70);
    e_az = run_axis(e_az, 0, 70, 1, 1, 0, 255);
    check("R3 R4 down, wrap", az, e_az);

    // R5: direct reversal and release restart at step one
    press(6'b000001); ticks(40);
    e_az = run_axis(e_az, 1, 40, 1, 1, 0, 255);
    check("R4 reversal setup", az, e_az);
    press(6'b000010); ticks(3);
    e_az = run_axis(e_az, 0, 3, 1, 1, 0, 255);
    check("R5 reversal step one", az, e_az);
    press(6'b0); press(6'b000010); ticks(5);
    e_az = run_axis(e_az, 0, 5, 1, 1, 0, 255);
    check("R5 release step one", az, e_az);
    press(6'b0);

    // R6: elevation saturation
    press(6'b000100); ticks(20);
    e_el = run_axis(e_el, 1, 20, 0, 1, 16, 112);
    check("R6 elevation up", el, e_el);
    ticks(100);
    e_el = 112;
    check("R6 elevation high clamp", el, e_el);
    press(6'b001000); ticks(40);
    e_el = run_axis(e_el, 0, 40, 0, 1, 16, 112);
    check("R6 elevation down", el, e_el);
    ticks(60);
    e_el = 16;
    check("R6 elevation low clamp", el, e_el);
    press(6'b0);

    // R7: viewing angle, unit step and clamps
    press(6'b010000); ticks(40);
    e_vw = 100;
    check("R7 view unit step", vw, e_vw);
    ticks(150);
    e_vw = 200;
    check("R7 view high clamp", vw, e_vw);
    press(6'b100000); ticks(250);
    e_vw = 8;
    check("R7 view low clamp", vw, e_vw);
    press(6'b0);

    // R8/R9: model chord, once per press, wrap at three
    press(6'b000011);
    e_m = 1;
    ticks(10);
    check_all("R8 R9 chord hold");
    press(6'b0); press(6'b000011);
    e_m = 2;
    check("R9 second press", msel, e_m);
    press(6'b0); press(6'b000011);
    e_m = 0;
    check("R9 wrap", msel, e_m);
    press(6'b0);

    // R10: reset chord
    press(6'b001100); ticks(15);
    check("R10 short hold no pulse", pulses, 0);
    press(6'b0); press(6'b001100); ticks(16);
    repeat (2) @(negedge clk);
    check("R10 pulse after 16", pulses, 1);
    ticks(30);
    check("R10 one pulse per hold", pulses, 1);
    check("R10 pulse width", wide, 0);
    check_all("R8 reset chord hold");
    press(6'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule